// File: doc/BRIEF.md
# Majority Vote over a Redundant-Digit Adder Tree

This block decides whether more than half of a wide vector of input bits are set. A word is presented on `in_bits` together with `in_valid`. The block counts the set bits and registers a one-bit verdict, which appears on `maj_out` one clock later. `maj_valid` marks the cycle in which a fresh verdict is available. With no strobe, the previous verdict holds.

The count comes from a balanced binary tree of adders of height ceil(log2 N). The input is padded with zeros up to a power of two. Leaves are one-digit numbers whose digit is 0 or 1. Each tree level adds pairs of numbers written in a redundant radix-2 form, in which every digit position holds a value from 0 to 3. Because of this form, a node needs only two rows of full adders and no carry ripple, whatever its width. Node widths grow by one digit per level. At the root, one ordinary binary addition turns the redundant number into a plain count. The count is then compared against the threshold. By default the threshold is N/2 rounded down, and a parameter can override it.

Top module: `maj_tree_vote`

## Requirements
- R1: When a word is accepted (`in_valid` high at a rising clock edge while `rst_n` is high), `maj_out` becomes 1 after that edge if the number of set bits in `in_bits` is strictly greater than N_BITS/2 (rounded down), and 0 otherwise.
- R2: For even N_BITS, a word with exactly N_BITS/2 set bits gives `maj_out` = 0, and one more set bit gives 1.
- R3: An accepted all-zero word gives `maj_out` = 0, and an accepted all-one word gives `maj_out` = 1.
- R4: `maj_valid` is 1 in the cycle after an edge where `in_valid` was sampled high, and 0 after an edge where it was sampled low.
- R5: In a cycle where `in_valid` is low, the value on `in_bits` has no effect: `maj_out` keeps its previous value.
- R6: At a rising edge with `rst_n` low, `maj_out` and `maj_valid` are cleared to 0, whatever the data inputs are.
- R7: When the THRESH parameter is set, `maj_out` is 1 exactly when the number of set bits is strictly greater than THRESH.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Strobe: accept `in_bits` at this edge |
| in_bits | input | N_BITS | Input vector to be voted on |
| maj_valid | output | 1 | A verdict from the previous edge is on `maj_out` |
| maj_out | output | 1 | Registered verdict: 1 if the set bits exceed the threshold |

## Verification
The assertions check several rules on every cycle: the strobe-to-valid relation, the holding of the verdict while no word is accepted, clearing under reset, the all-zero and all-one verdicts, and that the count recovered at the root never exceeds N_BITS. Whether the redundant-digit tree produces the correct count for arbitrary words can only be shown by the bench's scenarios. These scenarios cover an exhaustive sweep of every 8-bit word, random 32-bit words, and words placed exactly at and next to the half point. A separate 8-bit instance with an overridden threshold is also run.

// File: rtl/maj_pkg.sv
// Package maj_pkg
// Shared sizing helpers for the majority-vote tree.
// Assumes the input width is at least 2.
package maj_pkg;

    // Number of adder levels between the padded leaves and the root.
    function automatic int tree_levels(input int n_bits);
        return $clog2(n_bits);
    endfunction

    // Width of the binary count: enough bits for n_bits, plus one guard bit.
    function automatic int count_width(input int n_bits);
        return $clog2(n_bits + 1) + 1;
    endfunction

    // Default threshold: strict majority means the count must exceed this.
    function automatic int half_floor(input int n_bits);
        return n_bits / 2;
    endfunction

endpackage

// File: rtl/rdx_csa.sv
// Module rdx_csa
// A row of W full adders with no carry chain. It reduces three W-bit addends
// to a sum row and a carry row, so that x + y + z == s + 2*cy (mod 2^W).
// The carry of the top column would weigh 2^W, so it is not produced.
// Assumes W >= 2.
module rdx_csa #(
    parameter int W = 4
) (
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    input  logic [W-1:0] z,
    output logic [W-1:0] s,
    output logic [W-2:0] cy
);

    // Per-column parity and majority, with no dependence between columns.
    always_comb begin
        s  = x ^ y ^ z;
        cy = (x[W-2:0] & y[W-2:0]) | (x[W-2:0] & z[W-2:0]) | (y[W-2:0] & z[W-2:0]);
    end

endmodule

// File: rtl/rdx_node.sv
// Module rdx_node
// One interior node of the tree. It adds two redundant numbers of W-1 digits
// and yields a redundant number of W digits. A number is held as a pair
// (lo, hi) whose value is lo + 2*hi, so digit i = lo[i] + 2*hi[i], in 0..3.
// Two carry-save rows reduce the four binary addends to two, which keeps the
// node depth constant. The result is exact modulo 2^W. The tree keeps each
// subtree count below 2^W, so this is enough.
// Assumes W >= 3 (the bottom level uses rdx_leaf_pair instead).
module rdx_node #(
    parameter int W = 3
) (
    input  logic [W-2:0] a_lo,
    input  logic [W-3:0] a_hi,
    input  logic [W-2:0] b_lo,
    input  logic [W-3:0] b_hi,
    output logic [W-1:0] sum_lo,
    output logic [W-2:0] sum_hi
);

    logic [W-1:0] ax_lo, bx_lo, ax_hi2, bx_hi2;
    logic [W-1:0] s1, s1_cy2;
    logic [W-2:0] c1;

    // Align all four addends to W columns (hi rows carry weight 2).
    always_comb begin
        ax_lo  = {1'b0, a_lo};
        bx_lo  = {1'b0, b_lo};
        ax_hi2 = {1'b0, a_hi, 1'b0};
        bx_hi2 = {1'b0, b_hi, 1'b0};
    end

    rdx_csa #(.W(W)) u_row1 (
        .x  (ax_lo),
        .y  (bx_lo),
        .z  (ax_hi2),
        .s  (s1),
        .cy (c1)
    );

    // Shift the first carry row into its weight before the second reduction.
    always_comb s1_cy2 = {c1, 1'b0};

    rdx_csa #(.W(W)) u_row2 (
        .x  (s1),
        .y  (s1_cy2),
        .z  (bx_hi2),
        .s  (sum_lo),
        .cy (sum_hi)
    );

endmodule

// File: rtl/rdx_leaf_pair.sv
// Module rdx_leaf_pair
// Bottom tree level: it adds two single input bits. The result is a two-digit
// redundant number whose low row holds the parity and whose high row holds
// the pair carry. Assumes one-bit inputs.
module rdx_leaf_pair (
    input  logic       a,
    input  logic       b,
    output logic [1:0] sum_lo,
    output logic [0:0] sum_hi
);

    // Half adder expressed in the (lo, hi) form used across the tree.
    always_comb begin
        sum_lo = {1'b0, a ^ b};
        sum_hi = a & b;
    end

endmodule

// File: rtl/rdx_tree.sv
// Module rdx_tree
// A balanced tree that counts the set bits of in_bits. The input is padded
// with zeros to 2^LV leaves. Level lv holds 2^(LV-lv) redundant numbers of
// lv+1 digits. The root delivers the count in (lo, hi) form, with value
// root_lo + 2*root_hi. Assumes N_BITS >= 2.
module rdx_tree
    import maj_pkg::*;
#(
    parameter int N_BITS = 32,
    localparam int LV = tree_levels(N_BITS),
    localparam int LEAVES = 1 << LV
) (
    input  logic [N_BITS-1:0] in_bits,
    output logic [LV:0]       root_lo,
    output logic [LV-1:0]     root_hi
);

    for (genvar lv = 0; lv <= LV; lv++) begin : g_lvl
        localparam int CNT = LEAVES >> lv;
        if (lv == 0) begin : g_body
            logic lo [CNT];
            // Leaves: real inputs, then zero padding up to a power of two.
            for (genvar k = 0; k < CNT; k++) begin : g_leaf
                if (k < N_BITS) begin : g_real
                    always_comb lo[k] = in_bits[k];
                end else begin : g_pad
                    always_comb lo[k] = 1'b0;
                end
            end
        end else begin : g_body
            logic [lv:0]   lo [CNT];
            logic [lv-1:0] hi [CNT];
            for (genvar k = 0; k < CNT; k++) begin : g_add
                if (lv == 1) begin : g_pair
                    rdx_leaf_pair u_pair (
                        .a      (g_lvl[0].g_body.lo[2*k]),
                        .b      (g_lvl[0].g_body.lo[2*k+1]),
                        .sum_lo (lo[k]),
                        .sum_hi (hi[k])
                    );
                end else begin : g_node
                    rdx_node #(.W(lv+1)) u_node (
                        .a_lo   (g_lvl[lv-1].g_body.lo[2*k]),
                        .a_hi   (g_lvl[lv-1].g_body.hi[2*k]),
                        .b_lo   (g_lvl[lv-1].g_body.lo[2*k+1]),
                        .b_hi   (g_lvl[lv-1].g_body.hi[2*k+1]),
                        .sum_lo (lo[k]),
                        .sum_hi (hi[k])
                    );
                end
            end
        end
    end

    // The root node drives the tree outputs.
    always_comb begin
        root_lo = g_lvl[LV].g_body.lo[0];
        root_hi = g_lvl[LV].g_body.hi[0];
    end

endmodule

// File: rtl/rdx_to_bin.sv
// Module rdx_to_bin
// Single conversion at the root: sum over digits of d_i * 2^i, computed as
// lo + 2*hi with one carry-propagate adder of CW bits.
// Assumes CW >= DW (the count width already includes a guard bit).
module rdx_to_bin #(
    parameter int DW = 6,
    parameter int CW = 7
) (
    input  logic [DW-1:0] dig_lo,
    input  logic [DW-2:0] dig_hi,
    output logic [CW-1:0] count
);

    logic [CW-1:0] lo_x, hi_x;

    // Zero-extend both rows, then do the one ordinary addition.
    always_comb begin
        lo_x  = CW'(dig_lo);
        hi_x  = CW'({dig_hi, 1'b0});
        count = lo_x + hi_x;
    end

endmodule

// File: rtl/maj_tree_vote.sv
// Module maj_tree_vote
// Top level: registered strict-majority vote over N_BITS inputs.
// The count of set bits comes from a redundant-digit adder tree and is
// converted to binary once at the root. It is then compared against THRESH
// (by default N_BITS/2 rounded down). A strobed word yields its verdict after
// one clock edge; without a strobe the verdict holds.
// Assumes N_BITS >= 2 and 0 <= THRESH.
module maj_tree_vote
    import maj_pkg::*;
#(
    parameter int N_BITS = 32,
    parameter int THRESH = half_floor(N_BITS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [N_BITS-1:0] in_bits,
    output logic              maj_valid,
    output logic              maj_out
);

    localparam int LV = tree_levels(N_BITS);
    localparam int CW = count_width(N_BITS);

    logic [LV:0]   root_lo;
    logic [LV-1:0] root_hi;
    logic [CW-1:0] ones_cnt;
    logic          above;

    rdx_tree #(.N_BITS(N_BITS)) u_tree (
        .in_bits (in_bits),
        .root_lo (root_lo),
        .root_hi (root_hi)
    );

    rdx_to_bin #(.DW(LV+1), .CW(CW)) u_conv (
        .dig_lo (root_lo),
        .dig_hi (root_hi),
        .count  (ones_cnt)
    );

    // Threshold compare on the binary count.
    always_comb above = (int'(ones_cnt) > THRESH);

    // Verdict register: cleared by reset, loaded only on a strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            maj_valid <= 1'b0;
            maj_out   <= 1'b0;
        end else begin
            maj_valid <= in_valid;
            if (in_valid) begin
                maj_out <= above;
            end
        end
    end

    // The count recovered at the root cannot exceed the number of inputs.
    assert_count_in_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |-> (int'(ones_cnt) <= N_BITS));

    assert_valid_follows_R4: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> maj_valid);

    assert_valid_drops_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !maj_valid);

    assert_hold_when_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(maj_out));

    assert_zero_word_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_bits == '0) |=> !maj_out);

    if (THRESH < N_BITS) begin : g_ones_chk
        assert_ones_word_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && (&in_bits)) |=> maj_out);
    end

    assert_reset_clears_R6: assert property (@(posedge clk)
        !rst_n |=> (!maj_out && !maj_valid));

endmodule

// File: tb/maj_tree_vote_tb_top.sv
// Bench for maj_tree_vote. It drives three instances: 32 inputs (random and
// corner words), 8 inputs (every word), and 8 inputs with threshold 2.
// A behavioural model (popcount on integers) predicts each output.
module maj_tree_vote_tb_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        v32, v8;
    logic [31:0] b32;
    logic [7:0]  b8;
    logic        o32, o8, o8t, q32, q8, q8t;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // Expected outputs from the behavioural model.
    logic e32_v, e32_o, e8_v, e8_o, e8t_o;

    always #4 clk = ~clk;

    maj_tree_vote #(.N_BITS(32)) dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(v32), .in_bits(b32),
        .maj_valid(q32), .maj_out(o32));

    maj_tree_vote #(.N_BITS(8)) dut8_i (
        .clk(clk), .rst_n(rst_n), .in_valid(v8), .in_bits(b8),
        .maj_valid(q8), .maj_out(o8));

    maj_tree_vote #(.N_BITS(8), .THRESH(2)) dut8t_i (
        .clk(clk), .rst_n(rst_n), .in_valid(v8), .in_bits(b8),
        .maj_valid(q8t), .maj_out(o8t));

    task automatic chk(input string tag, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0b expected=%0b", tag, what, act, exp);
        end
    endtask

    function automatic string tag_of(input logic v, input int pop, input int n);
        if (!v) return "R5";
        if (pop == 0 || pop == n) return "R3";
        if (pop == n / 2 || pop == n / 2 + 1) return "R2";
        return "R1";
    endfunction

    // Apply one cycle of stimulus, then check at the following negedge.
    task automatic step(input logic nv32, input logic [31:0] nb32,
                        input logic nv8, input logic [7:0] nb8);
        int p32, p8;
        v32 = nv32; b32 = nb32; v8 = nv8; b8 = nb8;
        p32 = $countones(nb32);
        p8  = $countones(nb8);
        @(negedge clk);
        e32_v = nv32;
        e8_v  = nv8;
        if (nv32) e32_o = (p32 > 16);
        if (nv8) begin
            e8_o  = (p8 > 4);
            e8t_o = (p8 > 2);
        end
        chk(tag_of(nv32, p32, 32), "n32 maj_out", o32, e32_o);
        chk("R4", "n32 maj_valid", q32, e32_v);
        chk(tag_of(nv8, p8, 8), "n8 maj_out", o8, e8_o);
        chk("R4", "n8 maj_valid", q8, e8_v);
        chk(nv8 ? "R7" : "R5", "n8 thr2 maj_out", o8t, e8t_o);
    endtask

    // Hold reset for two edges with busy inputs; everything must read zero.
    task automatic do_reset();
        rst_n = 1'b0;
        v32 = 1'b1; b32 = '1; v8 = 1'b1; b8 = '1;
        repeat (2) @(negedge clk);
        chk("R6", "n32 out in reset", o32, 1'b0);
        chk("R6", "n32 valid in reset", q32, 1'b0);
        chk("R6", "n8 out in reset", o8, 1'b0);
        chk("R6", "n8 thr2 out in reset", o8t, 1'b0);
        e32_v = 0; e32_o = 0; e8_v = 0; e8_o = 0; e8t_o = 0;
        rst_n = 1'b1;
    endtask

    function automatic logic [31:0] k_ones(input int k);
        logic [31:0] w = '0;
        while ($countones(w) < k) w[$urandom_range(31, 0)] = 1'b1;
        return w;
    endfunction

    initial begin
        rst_n = 1'b0; v32 = 0; v8 = 0; b32 = '0; b8 = '0;
        do_reset();

        // Corner words for both widths.
        step(1, 32'h0, 1, 8'h00);
        step(1, 32'hFFFF_FFFF, 1, 8'hFF);
        step(1, 32'h0000_FFFF, 1, 8'h0F);
        step(1, 32'h5555_5555, 1, 8'hAA);
        step(1, 32'h0001_FFFF, 1, 8'h1F);
        step(1, 32'hFFFF_0000, 1, 8'h07);
        step(1, 32'h0000_7FFF, 1, 8'h08);

        // Idle cycles with junk on the inputs must not change the verdicts.
        step(1, 32'hFFFF_FFFF, 1, 8'hFF);
        step(0, 32'h0, 0, 8'h00);
        step(0, 32'h0000_0001, 0, 8'h01);
        step(1, 32'h0, 1, 8'h00);
        step(0, 32'hFFFF_FFFF, 0, 8'hFF);

        // Every 8-bit word; idle gaps are inserted periodically.
        for (int i = 0; i < 256; i++) begin
            step(1, $urandom, 1, i[7:0]);
            if (i % 16 == 7) step(0, $urandom, 0, 8'(~i));
        end

        // Random 32-bit words, weighted towards the half point.
        for (int i = 0; i < 1500; i++) begin
            logic [31:0] w;
            case ($urandom_range(3, 0))
                0: w = k_ones(16);
                1: w = k_ones(17);
                2: w = k_ones(15);
                default: w = $urandom;
            endcase
            step(($urandom_range(3, 0) != 0), w, ($urandom_range(3, 0) != 0), 8'($urandom));
        end

        // Reset in the middle of operation clears a high verdict.
        step(1, 32'hFFFF_FFFF, 1, 8'hFF);
        do_reset();
        step(0, 32'hFFFF_FFFF, 0, 8'hFF);
        step(1, k_ones(16), 1, 8'h33);
        step(1, k_ones(17), 1, 8'h37);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #(8 * 100000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule